// File: doc/BRIEF.md
# SPI-Mode Card Command Validator

This block sits on the card side of an SPI-mode storage interface. A bit-level shifter elsewhere assembles each 6-byte command frame. It then presents the command index, the 32-bit argument and the 7-bit checksum field together with a one-cycle valid strobe. The validator checks the checksum, decides whether the index may be executed in the card's present state, and returns a one-byte status response. A downstream command engine receives an execute strobe and the index only for commands that pass both checks.

The block keeps the card's power-up state. After reset, or after a reset command (index 0), the card is idle. In that state it accepts only index 0, index 1 (start initialization) and index 58 (read operating conditions). Initialization ends on a configurable number of accepted index-1 commands. The host polls with index 1 until the idle flag in the response reads 0. Checksum checking can be switched off with a configuration input.

Top module: `spi_cmd_check`

## Requirements
- R1: While reset is held and on the first cycle after it, `rsp_vld` and `exec_stb` are 0. The card starts idle, so the first accepted response has bit 0 set.
- R2: When `crc_en` is 1, the checksum is CRC-7 with polynomial x^7+x^3+1 (0x09), MSB first, with zero start value. It covers the 40 bits {2'b01, index, argument}. If `frm_crc` differs from it, response bit 3 is set and the command is rejected.
- R3: When `crc_en` is 0, a checksum mismatch has no effect: bit 3 stays 0 and a legal command is executed.
- R4: Once initialized, the supported indices are 0, 1, 9, 10, 12, 13, 16, 17, 18, 24, 25, 27, 28, 29, 30, 58 and 59. Any other index sets response bit 2 and is rejected. This covers undefined index 6, stream write 20, and interrupt and I/O indices 39 and 40.
- R5: While idle, only indices 0, 1 and 58 are legal. Every other index sets bit 2.
- R6: After reset, the card leaves idle on the INIT_POLLS-th accepted index-1 command. That response has bit 0 = 0. Earlier index-1 responses have bit 0 = 1, and every later response has bit 0 = 0 until an index-0 command.
- R7: An accepted index-0 command returns the card to idle and restarts the index-1 count. Its response has bit 0 = 1.
- R8: A rejected command (bit 2 or bit 3 set) leaves `exec_stb` low and changes neither the idle state nor the index-1 count.
- R9: `rsp_vld` is high exactly in the cycle after each `frm_vld` pulse. The response byte's bits 7, 6, 5, 4 and 1 are always 0, and bit 0 gives the idle state after the command.
- R10: An accepted command raises `exec_stb` for one cycle together with `rsp_vld`, with `exec_idx` equal to the received index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| crc_en | input | 1 | 1 enables checksum verification |
| frm_vld | input | 1 | One-cycle strobe: a full frame is present |
| frm_idx | input | 6 | Command index |
| frm_arg | input | 32 | Command argument |
| frm_crc | input | 7 | Received checksum field |
| rsp_vld | output | 1 | Response byte valid |
| rsp_byte | output | 8 | Status response |
| exec_stb | output | 1 | Accepted command, one cycle |
| exec_idx | output | 6 | Index of the last frame |

## Verification
A single frame can carry a checksum error and an illegal index at the same time. The bench provokes this by sending index 20 and index 6 with a corrupted checksum, both in idle and after initialization. It expects bits 2 and 3 set together with no execution. A second collision is a corrupted index-1 frame while polling: the bench counts the later polls to confirm it neither counted as a poll nor cleared the idle bit.

// File: rtl/spi_cmd_check.sv
module spi_cmd_check #(
  parameter int INIT_POLLS = 4,
  parameter int IDX_W      = 6,
  parameter int ARG_W      = 32,
  parameter int CRC_W      = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             crc_en,
  input  logic             frm_vld,
  input  logic [IDX_W-1:0] frm_idx,
  input  logic [ARG_W-1:0] frm_arg,
  input  logic [CRC_W-1:0] frm_crc,
  output logic             rsp_vld,
  output logic [7:0]       rsp_byte,
  output logic             exec_stb,
  output logic [IDX_W-1:0] exec_idx
);
  localparam int BODY_W = 2 + IDX_W + ARG_W;
  localparam int CNT_W  = $clog2(INIT_POLLS + 1);
  localparam logic [CRC_W-1:0] POLY = CRC_W'(7'h09);

  function automatic logic [CRC_W-1:0] crc_of(input logic [BODY_W-1:0] d);
    logic [CRC_W-1:0] c;
    logic fb;
    c = '0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = d[i] ^ c[CRC_W-1];
      c  = {c[CRC_W-2:0], 1'b0};
      if (fb) c = c ^ POLY;
    end
    return c;
  endfunction

  function automatic logic supported(input logic [IDX_W-1:0] i);
    case (int'(i))
      0, 1, 9, 10, 12, 13, 16, 17, 18,
      24, 25, 27, 28, 29, 30, 58, 59: return 1'b1;
      default: return 1'b0;
    endcase
  endfunction

  logic             idle_q;
  logic [CNT_W-1:0] polls_q;

  wire [BODY_W-1:0] body    = {2'b01, frm_idx, frm_arg};
  wire              crc_bad = crc_en && (crc_of(body) != frm_crc);
  wire              is_rst  = (frm_idx == IDX_W'(0));
  wire              is_init = (frm_idx == IDX_W'(1));
  wire              idle_ok = is_rst || is_init || (frm_idx == IDX_W'(58));
  wire              idx_bad = idle_q ? !idle_ok : !supported(frm_idx);
  wire              accept  = !crc_bad && !idx_bad;
  wire [CNT_W-1:0]  poll_inc = polls_q + CNT_W'(1);
  wire              done_now = idle_q && is_init && (int'(poll_inc) >= INIT_POLLS);

  logic             idle_nxt;
  logic [CNT_W-1:0] polls_nxt;

  always_comb begin
    idle_nxt  = idle_q;
    polls_nxt = polls_q;
    if (accept) begin
      if (is_rst) begin
        idle_nxt  = 1'b1;
        polls_nxt = '0;
      end else if (idle_q && is_init) begin
        polls_nxt = poll_inc;
        if (done_now) idle_nxt = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idle_q   <= 1'b1;
      polls_q  <= '0;
      rsp_vld  <= 1'b0;
      rsp_byte <= 8'h00;
      exec_stb <= 1'b0;
      exec_idx <= '0;
    end else begin
      rsp_vld  <= frm_vld;
      exec_stb <= frm_vld && accept;
      if (frm_vld) begin
        exec_idx <= frm_idx;
        idle_q   <= idle_nxt;
        polls_q  <= polls_nxt;
        rsp_byte <= {4'b0000, crc_bad, idx_bad, 1'b0, idle_nxt};
      end
    end
  end
endmodule

module spi_cmd_check_sva #(
  parameter int IDX_W = 6,
  parameter int ARG_W = 32,
  parameter int CRC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             crc_en,
  input logic             frm_vld,
  input logic [IDX_W-1:0] frm_idx,
  input logic [ARG_W-1:0] frm_arg,
  input logic [CRC_W-1:0] frm_crc,
  input logic             rsp_vld,
  input logic [7:0]       rsp_byte,
  input logic             exec_stb,
  input logic [IDX_W-1:0] exec_idx
);
  p_rsp_after_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> rsp_vld);
  p_no_stray_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> !rsp_vld);
  p_zero_bits_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_vld |-> (rsp_byte[7:4] == 4'h0) && !rsp_byte[1]);
  p_exec_clean_r8: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> rsp_byte[3:2] == 2'b00);
  p_exec_with_rsp_r10: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb |-> rsp_vld);
  p_exec_idx_r10: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld |=> exec_idx == $past(frm_idx));
  p_crc_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frm_vld && !crc_en |=> !rsp_byte[3]);
  p_idle_only_three_r5: assert property (@(posedge clk) disable iff (!rst_n)
    exec_stb && rsp_byte[0] |-> (exec_idx == IDX_W'(0)) || (exec_idx == IDX_W'(1)) || (exec_idx == IDX_W'(58)));
endmodule

bind spi_cmd_check spi_cmd_check_sva #(.IDX_W(IDX_W), .ARG_W(ARG_W), .CRC_W(CRC_W)) u_sva (.*);

// File: tb/sim_spi_cmd_check.sv
`timescale 1ns/1ps
module sim_spi_cmd_check;
  localparam int N = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        crc_en = 1'b1;
  logic        frm_vld = 1'b0;
  logic [5:0]  frm_idx = '0;
  logic [31:0] frm_arg = '0;
  logic [6:0]  frm_crc = '0;
  logic        rsp_vld;
  logic [7:0]  rsp_byte;
  logic        exec_stb;
  logic [5:0]  exec_idx;

  int checks = 0;
  int errors = 0;
  bit m_idle = 1'b1;
  int m_polls = 0;

  always #4 clk = ~clk;

  spi_cmd_check #(.INIT_POLLS(N)) u0 (.*);

  function automatic logic [6:0] ref_crc(input logic [39:0] d);
    logic [46:0] r;
    r = {d, 7'b0};
    for (int i = 46; i >= 7; i--)
      if (r[i]) r[i -: 8] = r[i -: 8] ^ 8'h89;
    return r[6:0];
  endfunction

  function automatic bit ref_sup(input int i);
    int lst[17] = '{0, 1, 9, 10, 12, 13, 16, 17, 18, 24, 25, 27, 28, 29, 30, 58, 59};
    foreach (lst[k]) if (lst[k] == i) return 1'b1;
    return 1'b0;
  endfunction

  task automatic chk(input string tag, input int got, input int exp, input string what);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic send(input int idx, input logic [31:0] arg, input bit corrupt);
    logic [6:0] good;
    bit bad_c, legal, acc, nidle;
    int npolls;
    string tag;
    good = ref_crc({2'b01, 6'(idx), arg});
    @(negedge clk);
    frm_vld = 1'b1; frm_idx = 6'(idx); frm_arg = arg;
    frm_crc = corrupt ? (good ^ 7'h11) : good;
    @(negedge clk);
    frm_vld = 1'b0;
    bad_c = crc_en && corrupt;
    legal = m_idle ? (idx == 0 || idx == 1 || idx == 58) : ref_sup(idx);
    acc = !bad_c && legal;
    nidle = m_idle; npolls = m_polls;
    if (acc && idx == 0) begin nidle = 1'b1; npolls = 0; end
    else if (acc && m_idle && idx == 1) begin
      npolls = m_polls + 1;
      if (npolls >= N) nidle = 1'b0;
    end
    if (bad_c) tag = "R2";
    else if (corrupt) tag = "R3";
    else if (!legal) tag = m_idle ? "R5" : "R4";
    else if (idx == 0) tag = "R7";
    else if (idx == 1) tag = "R6";
    else tag = "R10";
    chk("R9", int'(rsp_vld), 1, "rsp_vld");
    chk(tag, int'(rsp_byte), int'({4'b0, bad_c, !legal, 1'b0, nidle}), $sformatf("rsp_byte idx %0d", idx));
    chk(acc ? "R10" : "R8", int'(exec_stb), int'(acc), "exec_stb");
    if (acc) chk("R10", int'(exec_idx), idx, "exec_idx");
    m_idle = nidle; m_polls = npolls;
  endtask

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", int'(rsp_vld), 0, "rsp_vld in reset");
    chk("R1", int'(exec_stb), 0, "exec_stb in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(rsp_vld), 0, "rsp_vld after reset");
    chk("R1", int'(exec_stb), 0, "exec_stb after reset");

    for (int i = 0; i < 64; i++) if (i != 1) send(i, 32'h9E37_79B9 * i, 1'b0);
    send(20, 32'h1, 1'b1);
    send(6, 32'h2, 1'b1);
    for (int k = 0; k < 2 * N; k++) send(1, 32'h0, 1'b1);
    send(58, 32'h0, 1'b1);
    @(negedge clk);
    chk("R9", int'(rsp_vld), 0, "rsp_vld idle gap");

    for (int k = 0; k < N; k++) begin
      send(1, 32'h0, 1'b0);
      if (k == 0) send(1, 32'h0, 1'b1);
    end
    chk("R6", int'(m_idle), 0, "model left idle");

    for (int i = 0; i < 64; i++) if (i != 0) send(i, ~(32'h0101_0101 * i), 1'b0);
    for (int i = 0; i < 64; i += 3) if (i != 0) send(i, 32'hA5A5_0000 + i, 1'b1);
    send(20, 32'h5, 1'b1);
    send(6, 32'h6, 1'b1);

    crc_en = 1'b0;
    for (int i = 1; i < 64; i += 2) send(i, 32'h0F0F_F0F0 ^ i, 1'b1);
    send(0, 32'h0, 1'b1);
    send(9, 32'h0, 1'b1);
    for (int k = 0; k < N; k++) send(1, 32'h0, 1'b1);
    crc_en = 1'b1;
    send(9, 32'h1234, 1'b0);
    send(0, 32'h0, 1'b0);
    send(40, 32'h0, 1'b0);
    for (int k = 0; k < N; k++) send(1, 32'hFFFF_FFFF, 1'b0);
    send(39, 32'h0, 1'b0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule